// File: doc/BRIEF.md
# Shared-Line Interrupt Controller with Counting Masks

This block gathers a small number of interrupt lines, each of which may be driven by several devices, and presents one request to the processor. The devices that share a line are ORed inside the block into one composite signal, and every line is then synchronised by two flops. Each line has its own mode. In level mode the line requests for as long as the composite signal is high. In edge mode it requests only after a rising transition of that signal.

The processor reads which line is being serviced from `svc_line` while `cpu_irq` is high. It finishes service by writing an end-of-interrupt command. The same write port carries mask, unmask and mode commands for one line at a time. Masks nest through a per-line counter. A line is enabled only while its counter is zero, and an unmask issued with the counter already at zero sets a sticky error flag.

The control is a two-state machine:
- **ST_IDLE**: no line is being serviced.
- **ST_SERVICE**: one line is being serviced.

Transitions:
- **IDLE→SERVICE (grant)**: taken on the clock edge where at least one enabled line requests. The lowest-numbered requesting line is chosen.
- **SERVICE→IDLE (finish)**: taken on the clock edge that accepts an end-of-interrupt write.
- **IDLE→IDLE (wait)** and **SERVICE→SERVICE (hold)**: taken on every other edge.

Top module: `irqc_top`

## Requirements
- R1: After reset `cpu_irq` and `unmask_err` are low, every mask counter is zero and every line is in level mode.
- R2: A level-mode line whose composite input stays high raises `cpu_irq` and reports its index on `svc_line`.
- R3: After an end-of-interrupt write while a level line is still high, `cpu_irq` drops for exactly one cycle and is then high again for that line.
- R4: An edge-mode line requests only after a low-to-high transition. A line held high at end-of-interrupt raises no new request until it goes low and then high again.
- R5: An edge that arrives on a line while that same line is in service is held and serviced after end-of-interrupt. At most one such edge is held per line.
- R6: A masked line raises no request even while its input is high. An edge that arrives while the line is masked is discarded.
- R7: Masking nests. Each mask write increments the line's counter, each unmask write decrements it, and the line is enabled only when the counter is zero.
- R8: An unmask write to a line whose counter is zero leaves the counter at zero and sets `unmask_err`, which then stays high until reset.
- R9: When several enabled lines request, the lowest index is granted. `cpu_irq` and `svc_line` hold until end-of-interrupt, even if a lower-index line starts requesting during service.
- R10: The line input is the OR of its `DEVS_PER_LINE` device inputs. In level mode, a second device still high after the first clears causes re-service after end-of-interrupt.
- R11: A mode write (`wr_cmd`=3; `wr_data`=1 selects edge mode, 0 selects level mode) changes the line's mode and discards any edge held for that line.
- R12: Command encoding on `wr_cmd`: 0 is end-of-interrupt, 1 is mask, 2 is unmask, 3 is mode. `wr_line` selects the line, and a write takes effect on the clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_irq | input | NUM_LINES*DEVS_PER_LINE | Device requests; bit `l*DEVS_PER_LINE+d` is device d on line l |
| wr_en | input | 1 | Command write strobe |
| wr_cmd | input | 2 | Command code (0 end-of-interrupt, 1 mask, 2 unmask, 3 mode) |
| wr_line | input | $clog2(NUM_LINES) | Target line for mask, unmask and mode |
| wr_data | input | 1 | Mode value for mode writes (1 edge, 0 level) |
| cpu_irq | output | 1 | Request to the processor, high while a line is in service |
| svc_line | output | $clog2(NUM_LINES) | Index of the line in service |
| unmask_err | output | 1 | Sticky flag set by an unmask at a zero count |

## Verification
A wrong internal state shows up at the ports, and it shows up quickly.

- **Mask counter**: a counter that is off by one shows up as a line that is granted one unmask too early or too late. The error is visible in `cpu_irq` within three cycles of the unmask write.
- **Held edge**: a lost or duplicated held edge shows up as a missing or extra service two cycles after end-of-interrupt.
- **Edge detector**: a detector that treats a level as an edge re-raises `cpu_irq` after end-of-interrupt when it should stay low.
- **Arbitration**: a wrong priority or a grant that changes during service shows up as an unexpected `svc_line` while `cpu_irq` is high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        CMD_EOI    = 2'd0,
        CMD_MASK   = 2'd1,
        CMD_UNMASK = 2'd2,
        CMD_MODE   = 2'd3
    } irqc_cmd_e;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_EDGE  = 1'b1
    } irqc_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_SERVICE = 1'b1
    } irqc_state_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/irqc_line.sv
module irqc_line
    import irqc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic mask_cmd_i,
    input  logic unmask_cmd_i,
    input  logic mode_cmd_i,
    input  logic mode_val_i,
    input  logic grant_i,
    output logic req_o,
    output logic unmask_err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    irqc_mode_e       mode_q;
    logic             lvl_d_q;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;
    logic             enabled;

    assign rise    = lvl_i & ~lvl_d_q;
    assign enabled = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_LEVEL;
            lvl_d_q <= 1'b0;
            pend_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            lvl_d_q <= lvl_i;
            if (mode_cmd_i) begin
                mode_q <= irqc_mode_e'(mode_val_i);
            end
            if (mode_cmd_i) begin
                pend_q <= 1'b0;
            end else if (mode_q == MODE_EDGE && enabled && rise) begin
                pend_q <= 1'b1;
            end else if (grant_i) begin
                pend_q <= 1'b0;
            end
            if (mask_cmd_i && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (unmask_cmd_i && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        req_o = 1'b0;
        if (enabled) begin
            req_o = (mode_q == MODE_LEVEL) ? lvl_i : pend_q;
        end
    end

    assign unmask_err_o = unmask_cmd_i & (cnt_q == '0);

    AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(rise && mode_q == MODE_EDGE)); // R4

    AST_MASK_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_cmd_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7

    AST_UNMASK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_cmd_i && !mask_cmd_i && cnt_q == '0) |=> (cnt_q == '0)); // R8

    AST_MODE_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cmd_i |=> !pend_q); // R11
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req_i,
    output logic [NUM_LINES-1:0] onehot_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 any_o
);
    always_comb begin
        onehot_o = '0;
        idx_o    = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
                idx_o       = IDX_W'(i);
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_LINES     = 4,
    parameter int DEVS_PER_LINE = 2,
    parameter int CNT_W         = 4,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int DEV_W = NUM_LINES * DEVS_PER_LINE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEV_W-1:0] dev_irq,
    input  logic             wr_en,
    input  logic [1:0]       wr_cmd,
    input  logic [IDX_W-1:0] wr_line,
    input  logic             wr_data,
    output logic             cpu_irq,
    output logic [IDX_W-1:0] svc_line,
    output logic             unmask_err
);
    logic [NUM_LINES-1:0] composite;
    logic [NUM_LINES-1:0] lvl_sync;
    logic [NUM_LINES-1:0] line_req;
    logic [NUM_LINES-1:0] arb_onehot;
    logic [NUM_LINES-1:0] grant_fire;
    logic [NUM_LINES-1:0] line_err;
    logic [NUM_LINES-1:0] sel;
    logic [IDX_W-1:0]     arb_idx;
    logic                 arb_any;
    logic                 eoi;
    logic                 err_q;
    irqc_cmd_e            cmd;
    irqc_state_e          state_q, state_d;
    logic [IDX_W-1:0]     svc_q, svc_d;

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_or
            assign composite[g] = |dev_irq[g*DEVS_PER_LINE +: DEVS_PER_LINE];
            assign sel[g]       = wr_en && (wr_line == IDX_W'(g));
        end
    endgenerate

    irqc_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (composite),
        .sync_o  (lvl_sync)
    );

    assign cmd = irqc_cmd_e'(wr_cmd);
    assign eoi = wr_en && (cmd == CMD_EOI);

    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            irqc_line #(.CNT_W(CNT_W)) u_line (
                .clk          (clk),
                .rst_n        (rst_n),
                .lvl_i        (lvl_sync[g]),
                .mask_cmd_i   (sel[g] && cmd == CMD_MASK),
                .unmask_cmd_i (sel[g] && cmd == CMD_UNMASK),
                .mode_cmd_i   (sel[g] && cmd == CMD_MODE),
                .mode_val_i   (wr_data),
                .grant_i      (grant_fire[g]),
                .req_o        (line_req[g]),
                .unmask_err_o (line_err[g])
            );
        end
    endgenerate

    irqc_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
        .req_i    (line_req),
        .onehot_o (arb_onehot),
        .idx_o    (arb_idx),
        .any_o    (arb_any)
    );

    assign grant_fire = (state_q == ST_IDLE) ? arb_onehot : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            svc_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            svc_q   <= svc_d;
            err_q   <= err_q | (|line_err);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        svc_d   = svc_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arb_any) begin
                    state_d = ST_SERVICE;
                    svc_d   = arb_idx;
                end
            end
            ST_SERVICE: begin
                if (eoi) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_irq    = (state_q == ST_SERVICE);
        svc_line   = svc_q;
        unmask_err = err_q;
    end

    AST_GRANT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && arb_any) |=> cpu_irq); // R2

    AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && eoi) |=> !cpu_irq); // R3

    AST_HOLD_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && !eoi) |=> (cpu_irq && $stable(svc_line))); // R9

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_fire)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_err |=> unmask_err); // R8
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam int NL = 4;
    localparam int DP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL*DP-1:0] dev = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_cmd = '0;
    logic [1:0]    wr_line = '0;
    logic          wr_data = 1'b0;
    logic          cpu_irq;
    logic [1:0]    svc_line;
    logic          unmask_err;
    int            checks = 0;
    int            errors = 0;

    always #10 clk = ~clk;

    irqc_top #(.NUM_LINES(NL), .DEVS_PER_LINE(DP), .CNT_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev), .wr_en(wr_en),
        .wr_cmd(wr_cmd), .wr_line(wr_line), .wr_data(wr_data),
        .cpu_irq(cpu_irq), .svc_line(svc_line), .unmask_err(unmask_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_irq(input string req, input int exp);
        chk(cpu_irq == exp, req, cpu_irq, exp);
    endtask

    task automatic chk_svc(input string req, input int exp);
        chk(cpu_irq == 1 && svc_line == exp, req, cpu_irq ? svc_line : -1, exp);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] c, input logic [1:0] ln, input logic d);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = c; wr_line = ln; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int bitn);
        dev[bitn] = 1'b1; cyc(3);
        dev[bitn] = 1'b0; cyc(3);
    endtask

    task automatic t_reset;
        chk_irq("R1 irq after reset", 0);
        chk(unmask_err == 0, "R1 err after reset", unmask_err, 0);
    endtask

    task automatic t_level;
        dev[2] = 1'b1; cyc(4);
        chk_svc("R2 level grant", 1);
        cmd(2'd0, 0, 0);
        chk_irq("R3 drop after eoi", 0);
        cyc(1);
        chk_svc("R3 re-raise", 1);
        dev[2] = 1'b0; cyc(3);
        cmd(2'd0, 0, 0); cyc(3);
        chk_irq("R3 quiet once low", 0);
    endtask

    task automatic t_priority;
        dev[4] = 1'b1; dev[6] = 1'b1; cyc(4);
        chk_svc("R9 lowest of 2,3", 2);
        dev[0] = 1'b1; cyc(4);
        chk_svc("R9 hold until eoi", 2);
        cmd(2'd0, 0, 0); cyc(1);
        chk_svc("R9 line0 wins", 0);
        dev = '0; cyc(3);
        cmd(2'd0, 0, 0); cyc(1);
        chk_irq("R9 idle after release", 0);
    endtask

    task automatic t_edge;
        cmd(2'd3, 1, 1);
        dev[2] = 1'b1; cyc(4);
        chk_svc("R4 edge grant", 1);
        cmd(2'd0, 0, 0); cyc(4);
        chk_irq("R4 held high no retrigger", 0);
        dev[2] = 1'b0; cyc(3);
        dev[2] = 1'b1; cyc(4);
        chk_svc("R4 new edge", 1);
        dev[2] = 1'b0; cyc(3);
        cmd(2'd0, 0, 0); cyc(3);
        chk_irq("R4 idle", 0);
    endtask

    task automatic t_edge_pending;
        pulse(2);
        chk_svc("R5 first edge", 1);
        pulse(2); pulse(2);
        cmd(2'd0, 0, 0); cyc(1);
        chk_svc("R5 held edge served", 1);
        cmd(2'd0, 0, 0); cyc(4);
        chk_irq("R5 only one held", 0);
    endtask

    task automatic t_mask;
        cmd(2'd1, 0, 0); cmd(2'd1, 0, 0);
        dev[0] = 1'b1; cyc(5);
        chk_irq("R6 masked level ignored", 0);
        cmd(2'd2, 0, 0); cyc(4);
        chk_irq("R7 one unmask not enough", 0);
        cmd(2'd2, 0, 0); cyc(1);
        chk_svc("R7 enabled at zero", 0);
        dev[0] = 1'b0; cyc(3);
        cmd(2'd0, 0, 0);
        cmd(2'd1, 1, 0);
        pulse(2);
        cmd(2'd2, 1, 0); cyc(5);
        chk_irq("R6 masked edge discarded", 0);
    endtask

    task automatic t_unmask_err;
        chk(unmask_err == 0, "R8 err clear before", unmask_err, 0);
        cmd(2'd2, 2, 0); cyc(1);
        chk(unmask_err == 1, "R8 err set", unmask_err, 1);
        cmd(2'd1, 2, 0);
        dev[4] = 1'b1; cyc(4);
        chk_irq("R8 count stayed zero", 0);
        cmd(2'd2, 2, 0); cyc(1);
        chk_svc("R8 one unmask enables", 2);
        chk(unmask_err == 1, "R8 err sticky", unmask_err, 1);
        dev[4] = 1'b0; cyc(3);
        cmd(2'd0, 0, 0); cyc(3);
    endtask

    task automatic t_shared;
        dev[6] = 1'b1; cyc(4);
        chk_svc("R10 device A", 3);
        dev[7] = 1'b1; cyc(1);
        dev[6] = 1'b0; cyc(3);
        cmd(2'd0, 0, 0); cyc(1);
        chk_svc("R10 device B keeps line", 3);
        dev[7] = 1'b0; cyc(3);
        cmd(2'd0, 0, 0); cyc(3);
        chk_irq("R10 idle", 0);
    endtask

    task automatic t_mode_clear;
        pulse(2);
        chk_svc("R11 edge serviced", 1);
        pulse(2);
        cmd(2'd3, 1, 0);
        cmd(2'd0, 0, 0); cyc(4);
        chk_irq("R11 held edge dropped R12", 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_level();
        t_priority();
        t_edge();
        t_edge_pending();
        t_mask();
        t_unmask_err();
        t_shared();
        t_mode_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule